// File: doc/BRIEF.md
# Selectable Baud Clock Generator

This block turns one input clock into a set of bit-rate clocks at sixteen times the bit rate. It forwards one of them, picked by a 4-bit rate code, to a registered output. The input clock comes from one of two places: an oscillator input, or an external clock pin chosen by a mode input. All logic runs on a fast system clock `clk`. Rising edges of the chosen source are detected and act as the internal clock CO, and CO is also brought out as a level. With a 2.4576 MHz source, the fastest tap is 9600 Baud at 16 CO periods per bit. Every other rate scales in proportion to the source frequency.

A free-running counter gives the scan bits (CO divided by 8) and then a binary chain of taps from 9600 down to 75 Baud. Extra dividers on those taps give the irregular rates. Whole-ratio toggle dividers give 134.5, 200, 50 and 110 Baud. A fractional accumulator gives 1800 Baud. Two rate codes pass an external input `im` through instead of an internal rate, so a static level gives a zero-Baud output. Entering external-clock mode arms a one-shot clear of all counters and the output register. The clear fires on the first high level of the external pin.

Top module: `baud_clock_gen`

## Requirements
- R1: With `ext_sel`=0 the counters advance on rising edges of `osc_clk`. With `ext_sel`=1 they advance on rising edges of `ext_clk`, and `osc_clk` has no effect. `co` always equals the level of the selected source.
- R2: `scan_q` counts CO rising edges modulo 8.
- R3: Binary taps, with the period of `z` in CO periods and 50% duty: code 1000 gives 16; 1001 gives 32; 0111 and 1100 give 64; 1011 gives 128; 0110 gives 256; 1101 gives 512; 1110 gives 1024; 0011 gives 2048.
- R4: Whole-ratio taps with 50% duty: code 0100 gives 1152 CO periods (2400 tap divided by 18); 0101 gives 768 (1200 tap divided by 6); 0010 gives 3072 (the 0101 output divided by 4); 1111 gives 1408 (2400 tap divided by 22).
- R5: Code 1010 adds 3 modulo 16 to an accumulator on every toggle of the 9600 tap and toggles the output on each wrap. Periods of `z` repeat as 88, 88, 80 CO periods, so any three consecutive periods total 256.
- R6: Codes 0000 and 0001 route `im` to `z`. A static `im` level holds `z` at that level.
- R7: `z` is a register loaded only on CO rising edges. A change of `im` or the rate code reaches `z` only at the next CO rising edge.
- R8: After `ext_sel` rises, the first high level on `ext_clk` clears the counters and `z` once. Later `ext_clk` highs do not clear them again.
- R9: With `ext_sel`=0, a high level on `ext_clk` holds the counters and `z` at zero for as long as it lasts.
- R10: Active-low `rst_n` clears the counters, dividers and `z`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | 1 = use the external clock pin, 0 = use the oscillator input |
| osc_clk | input | 1 | Oscillator-path clock level |
| ext_clk | input | 1 | External clock pin level |
| rate_sel | input | 4 | Rate code choosing the signal sent to `z` |
| im | input | 1 | External frequency or level, routed by codes 0000 and 0001 |
| co | output | 1 | Selected source level (internal clock CO) |
| scan_q | output | 3 | Scan counter bits |
| z | output | 1 | Registered selected rate clock |

## Verification
`co` follows the source input in the same cycle. A CO rising edge driven on the inputs is detected at the next `clk` rising edge, and `scan_q`, the dividers and `z` all load at that edge. Their new values can therefore be seen one system-clock edge after the source input changes, and `z` shows a new rate code or `im` value on the first CO edge after that. The bench toggles the oscillator on every falling edge, so one CO period is two system clocks. It drives inputs and samples outputs 1 ns after each falling edge, away from the edge where the registers load. Periods and high times of `z` are counted in those samples and halved to get CO periods. Before the first period is counted, two rising edges of `z` are skipped, so a glitch from switching the code never reaches a checked value.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int SCAN_W  = 3;
    localparam int CHAIN_W = 8;
    localparam int SEL_W   = 4;

    typedef enum logic [SEL_W-1:0] {
        RS_PASS_A = 4'd0,  RS_PASS_B = 4'd1,  RS_B50   = 4'd2,  RS_B75   = 4'd3,
        RS_B134   = 4'd4,  RS_B200   = 4'd5,  RS_B600  = 4'd6,  RS_B2400 = 4'd7,
        RS_B9600  = 4'd8,  RS_B4800  = 4'd9,  RS_B1800 = 4'd10, RS_B1200 = 4'd11,
        RS_B2400X = 4'd12, RS_B300   = 4'd13, RS_B150  = 4'd14, RS_B110  = 4'd15
    } rate_sel_e;
endpackage

// File: rtl/clk_front.sv
module clk_front (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic osc_clk,
    input  logic ext_clk,
    output logic co,
    output logic tick,
    output logic mres
);
    typedef struct packed {
        logic src;
        logic sel;
        logic armed;
    } front_t;

    front_t s_d, s_q;
    logic   sel_rise, entry_pulse, hold_clr;

    always_comb begin
        co          = ext_sel ? ext_clk : osc_clk;
        tick        = co & ~s_q.src;
        sel_rise    = ext_sel & ~s_q.sel;
        entry_pulse = ext_sel & ext_clk & (s_q.armed | sel_rise);
        hold_clr    = ~ext_sel & ext_clk;
        mres        = hold_clr | entry_pulse;
        s_d.src     = co;
        s_d.sel     = ext_sel;
        s_d.armed   = ext_sel & (s_q.armed | sel_rise) & ~ext_clk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: entering external mode yields a single clear, not a train
    assert_single_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && mres) |=> !(ext_sel && mres))
        else $error("repeated clear in external mode");

    // R1: detected CO edges never occur on two consecutive cycles
    assert_tick_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("back-to-back CO edges");
endmodule

// File: rtl/toggle_div.sv
module toggle_div #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic out,
    output logic rise
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
    } tdiv_t;

    tdiv_t s_d, s_q;
    logic  at_end;

    always_comb begin
        at_end = (s_q.cnt == CW'(HALF - 1));
        s_d    = s_q;
        if (clr) begin
            s_d = '0;
        end else if (step) begin
            if (at_end) begin
                s_d.cnt = '0;
                s_d.out = ~s_q.out;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        out  = s_q.out;
        rise = step & ~clr & at_end & ~s_q.out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: the output moves only on a counted input edge
    assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(s_q.out))
        else $error("divider output moved without an input edge");

    // R4: the HALF-th counted edge flips the output
    assert_div_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && s_q.cnt == CW'(HALF - 1)) |=> (s_q.out != $past(s_q.out)))
        else $error("divider missed its toggle");
endmodule

// File: rtl/frac_div.sv
module frac_div #(
    parameter int ACC_W = 4,
    parameter int NUM   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic out
);
    localparam int WRAP_AT = (1 << ACC_W) - NUM;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             out;
    } frac_t;

    frac_t          s_d, s_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum = {1'b0, s_q.acc} + (ACC_W + 1)'(NUM);
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (step) begin
            s_d.acc = sum[ACC_W-1:0];
            if (sum[ACC_W]) s_d.out = ~s_q.out;
        end
        out = s_q.out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: accumulator and phase rest between steps
    assert_frac_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(s_q))
        else $error("fractional divider moved without a step");

    // R5: a step from the top band of the accumulator wraps and toggles
    assert_frac_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && s_q.acc >= ACC_W'(WRAP_AT)) |=> (s_q.out != $past(s_q.out)))
        else $error("fractional divider missed a wrap");
endmodule

// File: rtl/rate_chain.sv
module rate_chain
    import baud_pkg::*;
#(
    parameter int SW     = SCAN_W,
    parameter int CW     = CHAIN_W,
    parameter int H134   = 9,
    parameter int H200   = 3,
    parameter int H50    = 2,
    parameter int H110   = 11,
    parameter int FACC_W = 4,
    parameter int FNUM   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mres,
    output logic [SW-1:0] scan,
    output logic [CW-1:0] bin_taps,
    output logic          r1800,
    output logic          r134,
    output logic          r200,
    output logic          r50,
    output logic          r110
);
    localparam int NW  = SW + CW;
    localparam int K24 = SW + 2;
    localparam int K12 = SW + 3;

    typedef struct packed {
        logic [NW-1:0] cnt;
    } chain_t;

    chain_t s_d, s_q;
    logic   rise24, rise12, fstep, rise200;
    logic   unused_rise134, unused_rise110, unused_rise50;

    always_comb begin
        s_d = s_q;
        if (mres)      s_d.cnt = '0;
        else if (tick) s_d.cnt = s_q.cnt + 1'b1;
        rise24   = tick & ~mres & ~s_q.cnt[K24] & (&s_q.cnt[K24-1:0]);
        rise12   = tick & ~mres & ~s_q.cnt[K12] & (&s_q.cnt[K12-1:0]);
        fstep    = tick & ~mres & (&s_q.cnt[SW-1:0]);
        scan     = s_q.cnt[SW-1:0];
        bin_taps = s_q.cnt[NW-1:SW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    toggle_div #(.HALF(H134)) u_div134 (.clk(clk), .rst_n(rst_n), .clr(mres),
        .step(rise24), .out(r134), .rise(unused_rise134));
    toggle_div #(.HALF(H110)) u_div110 (.clk(clk), .rst_n(rst_n), .clr(mres),
        .step(rise24), .out(r110), .rise(unused_rise110));
    toggle_div #(.HALF(H200)) u_div200 (.clk(clk), .rst_n(rst_n), .clr(mres),
        .step(rise12), .out(r200), .rise(rise200));
    toggle_div #(.HALF(H50))  u_div50  (.clk(clk), .rst_n(rst_n), .clr(mres),
        .step(rise200), .out(r50), .rise(unused_rise50));
    frac_div #(.ACC_W(FACC_W), .NUM(FNUM)) u_frac (.clk(clk), .rst_n(rst_n),
        .clr(mres), .step(fstep), .out(r1800));

    // R2: each CO edge advances the counter by exactly one
    assert_scan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mres) |=> (s_q.cnt == NW'($past(s_q.cnt) + 1'b1)))
        else $error("counter skipped");

    // R1: without a CO edge the counter holds
    assert_scan_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !mres) |=> $stable(s_q.cnt))
        else $error("counter moved without CO edge");

    // R9: a clear leaves the counter at zero
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mres |=> (s_q.cnt == '0))
        else $error("clear did not zero the counter");
endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen
    import baud_pkg::*;
#(
    parameter int SW = SCAN_W,
    parameter int CW = CHAIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic             osc_clk,
    input  logic             ext_clk,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             im,
    output logic             co,
    output logic [SW-1:0]    scan_q,
    output logic             z
);
    typedef struct packed {
        logic z;
    } out_t;

    out_t          s_d, s_q;
    logic          tick, mres, pick;
    logic [CW-1:0] taps;
    logic          r1800, r134, r200, r50, r110;

    clk_front u_front (.clk(clk), .rst_n(rst_n), .ext_sel(ext_sel),
        .osc_clk(osc_clk), .ext_clk(ext_clk), .co(co), .tick(tick), .mres(mres));

    rate_chain #(.SW(SW), .CW(CW)) u_chain (.clk(clk), .rst_n(rst_n),
        .tick(tick), .mres(mres), .scan(scan_q), .bin_taps(taps),
        .r1800(r1800), .r134(r134), .r200(r200), .r50(r50), .r110(r110));

    always_comb begin
        case (rate_sel_e'(rate_sel))
            RS_PASS_A, RS_PASS_B: pick = im;
            RS_B50:               pick = r50;
            RS_B75:               pick = taps[7];
            RS_B134:              pick = r134;
            RS_B200:              pick = r200;
            RS_B600:              pick = taps[4];
            RS_B2400, RS_B2400X:  pick = taps[2];
            RS_B9600:             pick = taps[0];
            RS_B4800:             pick = taps[1];
            RS_B1800:             pick = r1800;
            RS_B1200:             pick = taps[3];
            RS_B300:              pick = taps[5];
            RS_B150:              pick = taps[6];
            RS_B110:              pick = r110;
            default:              pick = 1'b0;
        endcase
        s_d = s_q;
        if (mres)      s_d.z = 1'b0;
        else if (tick) s_d.z = pick;
        z = s_q.z;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: the output register loads only on CO edges
    assert_z_registered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !mres) |=> $stable(z))
        else $error("z changed between CO edges");

    // R8: any clear drops the output
    assert_z_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mres |=> !z)
        else $error("z survived a clear");
endmodule

// File: tb/baud_clock_gen_bench.sv
module baud_clock_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n, ext_sel, ext_clk, im, osc_run;
    logic       osc_clk = 1'b0;
    logic [3:0] rate_sel;
    logic       co, z;
    logic [2:0] scan_q;
    int         n_chk = 0;
    int         n_bad = 0;

    localparam int NROW = 14;
    localparam int CODES [NROW] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15};
    localparam int PER   [NROW] = '{3072, 2048, 1152, 768, 256, 64, 16, 32, 0,
                                    128, 64, 512, 1024, 1408};

    baud_clock_gen u_baud_clock_gen (.clk(clk), .rst_n(rst_n), .ext_sel(ext_sel),
        .osc_clk(osc_clk), .ext_clk(ext_clk), .rate_sel(rate_sel), .im(im),
        .co(co), .scan_q(scan_q), .z(z));

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!osc_run) osc_clk <= 1'b0;
        else          osc_clk <= ~osc_clk;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = z;
        step();
        while (!(!prev && z)) begin
            prev = z;
            step();
        end
    endtask

    task automatic measure(input int idx);
        int    exp, per, hi, total;
        logic  prev;
        string tag;
        exp = PER[idx];
        rate_sel = 4'(CODES[idx]);
        if (CODES[idx] == 10) tag = "R5 code 1010";
        else if (CODES[idx] == 2 || CODES[idx] == 4 || CODES[idx] == 5 || CODES[idx] == 15)
            tag = $sformatf("R4 code %0d", CODES[idx]);
        else tag = $sformatf("R3 code %0d", CODES[idx]);
        wait_rise();
        wait_rise();
        total = 0;
        for (int p = 0; p < 3; p++) begin
            per = 0;
            hi  = 0;
            do begin
                if (z) hi++;
                per++;
                prev = z;
                step();
            end while (!(!prev && z));
            total += per;
            if (exp != 0) begin
                check({tag, " period"}, per / 2, exp);
                check({tag, " duty"}, hi * 2, per);
            end else begin
                check({tag, " period in set"}, int'(per == 176 || per == 160), 1);
            end
        end
        if (exp == 0) check({tag, " three-period sum"}, total / 2, 256);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int q0;
        rst_n = 1'b0; ext_sel = 1'b0; ext_clk = 1'b0; im = 1'b0;
        osc_run = 1'b0; rate_sel = 4'hF;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        check("R10 reset z", int'(z), 0);
        check("R10 reset scan", int'(scan_q), 0);

        osc_run = 1'b1;
        repeat (3) step();
        for (int k = 0; k < 4; k++) begin
            q0 = int'(scan_q);
            check("R1 co follows osc", int'(co), int'(osc_clk));
            step(); step();
            check("R2 scan step", int'(scan_q), (q0 + 1) % 8);
        end

        for (int i = 0; i < NROW; i++) measure(i);

        rate_sel = 4'd0; im = 1'b1;
        repeat (6) step();
        check("R6 pass code 0000 high", int'(z), 1);
        rate_sel = 4'd1; im = 1'b0;
        repeat (6) step();
        check("R6 pass code 0001 low", int'(z), 0);

        osc_run = 1'b0;
        repeat (3) step();
        im = 1'b1;
        repeat (6) step();
        check("R7 no CO edge keeps z", int'(z), 0);
        osc_run = 1'b1;
        repeat (4) step();
        check("R7 z loads on CO edge", int'(z), 1);

        while (scan_q == 3'd0) step();
        osc_run = 1'b0;
        repeat (3) step();
        ext_sel = 1'b1;
        repeat (2) step();
        check("R8 no clear before pin high", int'(scan_q != 3'd0), 1);
        check("R8 z before entry clear", int'(z), 1);
        ext_clk = 1'b1;
        step();
        check("R8 entry clear scan", int'(scan_q), 0);
        check("R8 entry clear z", int'(z), 0);
        step(); step();
        for (int k = 0; k < 5; k++) begin
            ext_clk = 1'b0; step();
            ext_clk = 1'b1; step();
            check("R1 co follows ext pin", int'(co), 1);
        end
        check("R8 no second clear", int'(scan_q), 5);
        osc_run = 1'b1;
        repeat (10) step();
        check("R1 osc ignored in external mode", int'(scan_q), 5);

        ext_sel = 1'b0;
        repeat (10) step();
        check("R9 hold clear scan", int'(scan_q), 0);
        check("R9 hold clear z", int'(z), 0);
        ext_clk = 1'b0;
        repeat (8) step();
        check("R9 counting resumes", int'(scan_q != 3'd0), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule